// File: doc/BRIEF.md
# Connection Memory Block Programmer

This block fills two connection memories, a backplane memory and a local memory, in a single pass. Each memory holds 16-bit words. Every word of the backplane memory receives a 3-bit backplane pattern in its top bits, and every word of the local memory receives a separate 3-bit local pattern in its top bits. The lower 13 bits of every word are forced to zero. Software loads both patterns and sets an enable bit through a small programming register. The fill only starts while an external master programming control is high.

The sweep is timed by frames. After the enable edge the block waits for the next frame pulse. It then writes one address per clock into both memories at once, from address 0 up to `DEPTH-1`. When the following frame pulse arrives, the operation completes and the enable bit clears itself. Software can stop a fill early in two ways: by writing the enable bit low, or by dropping the master control. Words that have already been written keep their new contents.

The sequencer has four states:
- `ST_IDLE`: no fill in progress.
- `ST_ARMED`: enabled and waiting for a frame boundary.
- `ST_SWEEP`: writing one address per cycle.
- `ST_DRAIN`: every address is written and the block waits for the closing frame boundary.

The transitions between them are:
- `ST_IDLE` to `ST_ARMED` on a start.
- `ST_ARMED` to `ST_SWEEP` on a frame pulse.
- `ST_SWEEP` to `ST_DRAIN` after the last address.
- `ST_DRAIN` to `ST_IDLE` on a frame pulse. This is completion.
- Any busy state to `ST_IDLE` on an abort.

Top module: `cm_fill_engine`

## Requirements
- R1: After reset `reg_rdata` reads 0 and neither memory write enable is asserted.
- R2: The programming register reads back with the backplane pattern in bits 6:4, the local pattern in bits 3:1 and the enable flag in bit 0. Bits 15:7 read as zero. While idle, a register write loads both pattern fields.
- R3: A register write with bit 0 = 1 while the enable flag is 0 and `master_en` = 1 sets the enable flag. If `master_en` = 0, that write leaves the flag at 0 and no memory writes follow.
- R4: No memory write occurs before the first `frame_pulse` after the start. In the cycle after that pulse is sampled, address 0 is written. Each following cycle writes the next ascending address, up to `DEPTH-1`.
- R5: Each backplane write carries data {backplane pattern, 13'b0} and each local write carries {local pattern, 13'b0}. Both memories are written at the same address in the same cycles.
- R6: The enable flag stays 1 after the last address until the next `frame_pulse`. It reads 0, with no writes, from the cycle after that pulse is sampled.
- R7: A register write with bit 0 = 0 while the flag is 1 aborts the fill. From the next cycle there are no writes and the flag reads 0.
- R8: Driving `master_en` low while the flag is 1 aborts the fill with the same timing as R7.
- R9: While the flag is 1, register writes do not change either pattern field.
- R10: A completed fill writes every address 0 to `DEPTH-1` exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master block-programming permission from the control register |
| frame_pulse | input | 1 | One-cycle frame boundary marker |
| reg_wr | input | 1 | Programming register write strobe |
| reg_wdata | input | 7 | Write data: bit 0 enable, 3:1 local pattern, 6:4 backplane pattern |
| reg_rdata | output | 16 | Programming register read-back |
| bcm_we | output | 1 | Backplane memory write enable |
| bcm_addr | output | ADDR_W | Backplane memory address |
| bcm_wdata | output | 16 | Backplane memory write data |
| lcm_we | output | 1 | Local memory write enable |
| lcm_addr | output | ADDR_W | Local memory address |
| lcm_wdata | output | 16 | Local memory write data |

## Verification
The assertions check the following on every cycle:
- The first write of a sweep goes to address 0, and each later write steps the address by one.
- No write happens while the block is armed without a frame pulse.
- The pattern fields hold while the block is enabled.
- Both abort paths clear the flag, and a start without master permission is refused.
- Writes occur only while the flag is set, and the flag tracks the sequencer's busy state.

Only the bench scenarios can show that a whole frame covers every address exactly once with the right data in both memories, that completion waits for the closing frame pulse, and that an aborted sweep stays silent through later frames.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SWEEP = 2'd2,
        ST_DRAIN = 2'd3
    } fill_state_e;
endpackage

// File: rtl/cmf_prog_reg.sv
module cmf_prog_reg #(
    parameter int PAT_W = 3,
    parameter int REG_W = 16,
    localparam int FIELD_W = 2 * PAT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [FIELD_W-1:0] reg_wdata,
    input  logic               master_en,
    input  logic               done,
    output logic               ben,
    output logic [PAT_W-1:0]   bpat,
    output logic [PAT_W-1:0]   lpat,
    output logic               start,
    output logic               abort,
    output logic [REG_W-1:0]   reg_rdata
);

    always_comb begin
        start     = reg_wr && reg_wdata[0] && !ben && master_en;
        abort     = ben && ((reg_wr && !reg_wdata[0]) || !master_en);
        reg_rdata = {{(REG_W - FIELD_W){1'b0}}, bpat, lpat, ben};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ben  <= 1'b0;
            bpat <= '0;
            lpat <= '0;
        end else begin
            if (abort || done) begin
                ben <= 1'b0;
            end else if (start) begin
                ben <= 1'b1;
            end
            if (reg_wr && !ben) begin
                bpat <= reg_wdata[2*PAT_W:PAT_W+1];
                lpat <= reg_wdata[PAT_W:1];
            end
        end
    end

    assert_fields_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ben |=> ($stable(bpat) && $stable(lpat)));

    assert_write_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ben && reg_wr && !reg_wdata[0]) |=> !ben);

    assert_master_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ben && !master_en) |=> !ben);

    assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ben && reg_wr && reg_wdata[0] && !master_en) |=> !ben);

endmodule

// File: rtl/cmf_sweep_fsm.sv
module cmf_sweep_fsm
    import cmf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              frame_pulse,
    output logic              busy,
    output logic              sweep_we,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    fill_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        state_d = state_q;
        addr_d  = addr;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (frame_pulse) begin
                    state_d = ST_SWEEP;
                    addr_d  = '0;
                end
            end
            ST_SWEEP: begin
                if (addr == LAST_ADDR) begin
                    state_d = ST_DRAIN;
                end else begin
                    addr_d = addr + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (frame_pulse) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr    <= '0;
        end else begin
            state_q <= state_d;
            addr    <= addr_d;
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        sweep_we = (state_q == ST_SWEEP);
        done     = (state_q == ST_DRAIN) && frame_pulse && !abort;
    end

    assert_first_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sweep_we) |-> (addr == '0));

    assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sweep_we && $past(sweep_we)) |-> (addr == ADDR_W'($past(addr) + 1'b1)));

    assert_wait_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !frame_pulse) |=> !sweep_we);

endmodule

// File: rtl/cm_fill_engine.sv
module cm_fill_engine #(
    parameter int DEPTH = 32,
    parameter int WORD_W = 16,
    parameter int PAT_W = 3,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int FIELD_W = 2 * PAT_W + 1,
    localparam int ZERO_W = WORD_W - PAT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               master_en,
    input  logic               frame_pulse,
    input  logic               reg_wr,
    input  logic [FIELD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               bcm_we,
    output logic [ADDR_W-1:0]  bcm_addr,
    output logic [WORD_W-1:0]  bcm_wdata,
    output logic               lcm_we,
    output logic [ADDR_W-1:0]  lcm_addr,
    output logic [WORD_W-1:0]  lcm_wdata
);

    logic              ben, start, abort, done, busy, sweep_we;
    logic [PAT_W-1:0]  bpat, lpat;
    logic [ADDR_W-1:0] addr;

    cmf_prog_reg #(.PAT_W(PAT_W), .REG_W(WORD_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .master_en (master_en),
        .done      (done),
        .ben       (ben),
        .bpat      (bpat),
        .lpat      (lpat),
        .start     (start),
        .abort     (abort),
        .reg_rdata (reg_rdata)
    );

    cmf_sweep_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .abort       (abort),
        .frame_pulse (frame_pulse),
        .busy        (busy),
        .sweep_we    (sweep_we),
        .addr        (addr),
        .done        (done)
    );

    always_comb begin
        bcm_we    = sweep_we;
        lcm_we    = sweep_we;
        bcm_addr  = addr;
        lcm_addr  = addr;
        bcm_wdata = {bpat, {ZERO_W{1'b0}}};
        lcm_wdata = {lpat, {ZERO_W{1'b0}}};
    end

    assert_write_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bcm_we |-> ben);

    assert_flag_tracks_fsm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ben == busy);

endmodule

// File: tb/cm_fill_engine_tb.sv
`timescale 1ns/1ps
module cm_fill_engine_tb;
    localparam int DEPTH = 32;
    localparam int FRAME = 40;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b1;
    logic frame_pulse = 1'b0;
    logic reg_wr = 1'b0;
    logic [6:0] reg_wdata = '0;
    logic [15:0] reg_rdata, bcm_wdata, lcm_wdata;
    logic bcm_we, lcm_we;
    logic [AW-1:0] bcm_addr, lcm_addr;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cm_fill_engine #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .frame_pulse(frame_pulse),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bcm_we(bcm_we), .bcm_addr(bcm_addr), .bcm_wdata(bcm_wdata),
        .lcm_we(lcm_we), .lcm_addr(lcm_addr), .lcm_wdata(lcm_wdata)
    );

    function automatic logic [15:0] exp_rd(input logic [2:0] b, input logic [2:0] l, input logic en);
        return {9'b0, b, l, en};
    endfunction

    function automatic logic [15:0] exp_word(input logic [2:0] p);
        return {p, 13'b0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [6:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic pulse_frame();
        frame_pulse = 1'b1;
        step();
        frame_pulse = 1'b0;
    endtask

    task automatic run_fill(input logic [2:0] b, input logic [2:0] l);
        bit seen [DEPTH];
        int nwr = 0, order_err = 0, b_err = 0, l_err = 0, early = 0, dup = 0;
        foreach (seen[k]) seen[k] = 1'b0;
        reg_write({b, l, 1'b1});
        check(reg_rdata == exp_rd(b, l, 1'b1), "R3 start", reg_rdata, exp_rd(b, l, 1'b1));
        reg_write({~b, ~l, 1'b1});
        check(reg_rdata == exp_rd(b, l, 1'b1), "R9 fields held", reg_rdata, exp_rd(b, l, 1'b1));
        for (int i = 0; i < 3; i++) begin
            if (bcm_we || lcm_we) early++;
            step();
        end
        check(early == 0, "R4 no write before frame", early, 0);
        pulse_frame();
        for (int i = 0; i < FRAME; i++) begin
            if (bcm_we) begin
                if (bcm_addr != AW'(nwr)) order_err++;
                if (seen[bcm_addr]) dup++;
                seen[bcm_addr] = 1'b1;
                if (bcm_wdata != exp_word(b)) b_err++;
                if (!lcm_we || lcm_addr != bcm_addr || lcm_wdata != exp_word(l)) l_err++;
                nwr++;
            end
            if (i == FRAME - 1) begin
                check(reg_rdata[0] == 1'b1, "R6 flag held until frame", reg_rdata, 1);
                frame_pulse = 1'b1;
            end
            step();
            frame_pulse = 1'b0;
        end
        check(order_err == 0, "R4 ascending from 0", order_err, 0);
        check(b_err == 0, "R5 backplane data", b_err, 0);
        check(l_err == 0, "R5 local data and address", l_err, 0);
        check(nwr == DEPTH && dup == 0, "R10 each address once", nwr, DEPTH);
        check(reg_rdata == exp_rd(b, l, 1'b0) && !bcm_we, "R6 self clear", reg_rdata, exp_rd(b, l, 1'b0));
    endtask

    task automatic run_abort(input bit by_master);
        int nwr = 0, late = 0;
        reg_write({3'b101, 3'b010, 1'b1});
        pulse_frame();
        for (int i = 0; i < 5; i++) begin
            if (bcm_we) nwr++;
            step();
        end
        if (by_master) begin
            master_en = 1'b0;
            step();
        end else begin
            reg_write(7'b0);
        end
        if (by_master) begin
            check(!bcm_we && !lcm_we && reg_rdata[0] == 1'b0, "R8 master abort", reg_rdata, 0);
        end else begin
            check(!bcm_we && !lcm_we && reg_rdata[0] == 1'b0, "R7 write abort", reg_rdata, 0);
        end
        for (int i = 0; i < FRAME + 4; i++) begin
            if (bcm_we || lcm_we) late++;
            if (i == 10) frame_pulse = 1'b1;
            step();
            frame_pulse = 1'b0;
        end
        if (by_master) check(late == 0 && nwr == 5, "R8 silent after abort", late, 0);
        else check(late == 0 && nwr == 5, "R7 silent after abort", late, 0);
        master_en = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int late;
        void'($urandom(32'd4711));
        step();
        step();
        check(reg_rdata == 16'h0 && !bcm_we && !lcm_we, "R1 reset state", reg_rdata, 0);
        rst_n = 1'b1;
        step();
        check(reg_rdata == 16'h0 && !bcm_we, "R1 after release", reg_rdata, 0);

        reg_write(7'b1111110);
        check(reg_rdata == exp_rd(3'b111, 3'b111, 1'b0), "R2 idle field load", reg_rdata, exp_rd(3'b111, 3'b111, 1'b0));
        reg_write(7'b0100110);
        check(reg_rdata == exp_rd(3'b010, 3'b011, 1'b0), "R2 layout", reg_rdata, exp_rd(3'b010, 3'b011, 1'b0));

        master_en = 1'b0;
        reg_write(7'b0010011);
        check(reg_rdata[0] == 1'b0, "R3 start refused without master", reg_rdata, 0);
        late = 0;
        pulse_frame();
        for (int i = 0; i < 5; i++) begin
            if (bcm_we) late++;
            step();
        end
        check(late == 0, "R3 no writes without master", late, 0);
        master_en = 1'b1;

        run_fill(3'b101, 3'b011);
        run_fill(3'b000, 3'b111);
        run_abort(1'b0);
        run_abort(1'b1);
        for (int r = 0; r < 3; r++) begin
            logic [2:0] rb = 3'($urandom_range(0, 7));
            logic [2:0] rl = 3'($urandom_range(0, 7));
            run_fill(rb, rl);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule